// File: doc/BRIEF.md
# Scanline Pixel Fetch Requester

This block sits between the video timing logic and the memory read port of a raster display pipeline. When the timing side asks for a display row, the block works out where that row starts in a word-addressed frame store. It then reads the row as a fixed sequence of bursts through a request/acknowledge read port. Each returned 64-bit beat carries two pixels. The block takes the 6-bit red, green and blue fields of both pixels and writes them as one 36-bit entry into a line buffer write port.

Each pixel occupies one 32-bit word, and rows sit 4096 bytes apart. Only the visible 640 columns of the visible 480 rows are read. A fetch that has not finished when the next row request arrives is dropped, and the new row starts at once. While the display enable is low the block issues nothing and holds its counters at zero.

Top module: `scanline_fetch`

## Requirements
- R1: The read address of burst n (n = 0..19) of a row equals (frame_base with its low 21 bits cleared) + 4096*row + 128*n. frame_base and row are sampled in the cycle that line_req is accepted, and later changes of frame_base do not affect the row in progress.
- R2: A row is fetched as exactly 20 bursts of 16 beats. After the last beat of the 20th burst, rd_req stays low until the next accepted line_req.
- R3: rd_req rises in the cycle after a line_req is accepted, and in the cycle after the 16th beat of a non-final burst. It stays high with a stable rd_addr until rd_ack is seen, and is low in the cycle after the acknowledge. It is low out of reset.
- R4: A beat is accepted, and buf_we asserted in the same cycle, only while rd_valid is high after a burst has been acknowledged and before its 16 beats are complete. rd_valid at any other time writes nothing.
- R5: buf_data[35:18] holds the pixel in rd_data[63:32], and buf_data[17:0] holds the pixel in rd_data[31:0]. Each 18-bit field is {red, green, blue}, taken from bits [23:18], [15:10] and [7:2] of the 32-bit pixel word (bit 31 is the most significant). All other word bits are ignored.
- R6: buf_addr equals the index of the beat within the row, 0 to 319. It restarts at 0 on every accepted line_req.
- R7: An accepted line_req during an unfinished row abandons the rest of that row. The next request is burst 0 of the new row.
- R8: While disp_en is low, rd_req and buf_we are low in that same cycle, line_req is ignored and all counters return to zero. After disp_en returns high, nothing is requested until a new line_req.
- R9: A line_req with line_row of 480 or more is ignored. The fetch in progress, or the idle state, continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_en | input | 1 | Display enable; low halts all fetching |
| frame_base | input | 32 | Frame store byte base; top 11 bits used |
| line_req | input | 1 | One-cycle request to fetch a row |
| line_row | input | 9 | Row number for line_req |
| rd_req | output | 1 | Burst read request, held until acknowledged |
| rd_addr | output | 32 | Byte address of the requested burst |
| rd_ack | input | 1 | Burst request acknowledge |
| rd_valid | input | 1 | Read data beat strobe |
| rd_data | input | 64 | Read data beat, two pixel words |
| buf_we | output | 1 | Line buffer write enable |
| buf_addr | output | 9 | Line buffer write address |
| buf_data | output | 36 | Two packed 18-bit pixels |

## Verification
The bench builds the block with its default parameters: 640 visible columns, 480 visible rows, 16-beat bursts and 11 kept base bits. This gives the real 20-burst row and the real 4096-byte row stride. It covers the last burst of a row, the row boundary at 479/480 and the 2 MB base alignment with full-size addresses. Random acknowledge delays, gaps between beats and stray rd_valid pulses are mixed with directed rows 0 and 479. Directed cases also cover abandoned rows, a disable pulse in mid-row and out-of-range rows.

// File: rtl/scanline_fetch.sv
`timescale 1ns/1ps
module scanline_fetch #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_W     = 64,
  parameter int VIS_COLS   = 640,
  parameter int VIS_ROWS   = 480,
  parameter int MEM_ROWS   = 512,
  parameter int ROW_BYTES  = 4096,
  parameter int BURST_LEN  = 16,
  parameter int BASE_KEEP  = 11,
  parameter int COLOR_W    = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disp_en,
  input  logic [ADDR_W-1:0]     frame_base,
  input  logic                  line_req,
  input  logic [$clog2(MEM_ROWS)-1:0] line_row,
  output logic                  rd_req,
  output logic [ADDR_W-1:0]     rd_addr,
  input  logic                  rd_ack,
  input  logic                  rd_valid,
  input  logic [BEAT_W-1:0]     rd_data,
  output logic                  buf_we,
  output logic [$clog2(VIS_COLS*32/BEAT_W)-1:0] buf_addr,
  output logic [3*COLOR_W*(BEAT_W/32)-1:0]      buf_data
);
  localparam int PIX_PER_BEAT = BEAT_W / 32;
  localparam int LINE_BEATS   = VIS_COLS / PIX_PER_BEAT;
  localparam int LINE_BURSTS  = LINE_BEATS / BURST_LEN;
  localparam int BURST_BYTES  = BURST_LEN * BEAT_W / 8;
  localparam int BURST_SHIFT  = $clog2(BURST_BYTES);
  localparam int ROW_SHIFT    = $clog2(ROW_BYTES);
  localparam int PIX_W        = 3 * COLOR_W;
  localparam int WA_W         = $clog2(LINE_BEATS);
  localparam int BU_W         = $clog2(LINE_BURSTS);
  localparam int BT_W         = $clog2(BURST_LEN);
  localparam int ROW_W        = $clog2(MEM_ROWS);
  localparam logic [ADDR_W-1:0] BASE_MASK =
    ~((ADDR_W'(1) << (ADDR_W - BASE_KEEP)) - ADDR_W'(1));
  localparam int RED_LO = 18, GRN_LO = 10, BLU_LO = 2;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA} st_t;

  st_t               state;
  logic [ADDR_W-1:0] row_base;
  logic [BU_W-1:0]   burst;
  logic [BT_W-1:0]   beat;
  logic [WA_W-1:0]   wr_addr;
  logic              accept;

  assign accept   = line_req && (line_row < ROW_W'(VIS_ROWS));
  assign rd_req   = disp_en && (state == S_REQ);
  assign rd_addr  = row_base + (ADDR_W'(burst) << BURST_SHIFT);
  assign buf_we   = disp_en && (state == S_DATA) && rd_valid;
  assign buf_addr = wr_addr;

  for (genvar p = 0; p < PIX_PER_BEAT; p++) begin : g_pack
    logic [31:0] word;
    assign word = rd_data[BEAT_W-1-32*p -: 32];
    assign buf_data[PIX_W*PIX_PER_BEAT-1-PIX_W*p -: PIX_W] =
      {word[RED_LO +: COLOR_W], word[GRN_LO +: COLOR_W], word[BLU_LO +: COLOR_W]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !disp_en) begin
      state    <= S_IDLE;
      row_base <= '0;
      burst    <= '0;
      beat     <= '0;
      wr_addr  <= '0;
    end else if (accept) begin
      state    <= S_REQ;
      row_base <= (frame_base & BASE_MASK) + (ADDR_W'(line_row) << ROW_SHIFT);
      burst    <= '0;
      beat     <= '0;
      wr_addr  <= '0;
    end else begin
      case (state)
        S_REQ:  if (rd_ack) state <= S_DATA;
        S_DATA: if (rd_valid) begin
          wr_addr <= wr_addr + WA_W'(1);
          if (beat == BT_W'(BURST_LEN - 1)) begin
            beat <= '0;
            if (burst == BU_W'(LINE_BURSTS - 1)) state <= S_IDLE;
            else begin
              burst <= burst + BU_W'(1);
              state <= S_REQ;
            end
          end else begin
            beat <= beat + BT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack && !line_req |=> !disp_en || (rd_req && $stable(rd_addr)));
  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack && !line_req |=> !rd_req);
  // R8
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> state == S_IDLE && wr_addr == '0);
  // R6
  waddr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> buf_addr < WA_W'(LINE_BEATS));
  // R6
  waddr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we && !line_req && buf_addr != WA_W'(LINE_BEATS - 1)
      |=> !disp_en || wr_addr == $past(wr_addr) + WA_W'(1));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && !line_req |=> !rd_req);
  // R9
  bad_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_req && line_row >= ROW_W'(VIS_ROWS) && state == S_IDLE |=> state == S_IDLE);
endmodule

// File: tb/scanline_fetch_tb.sv
`timescale 1ns/1ps
module scanline_fetch_tb_top;
  logic        clk = 0, rst_n = 0, disp_en = 0, line_req = 0;
  logic [31:0] frame_base = 0;
  logic [8:0]  line_row = 0;
  logic        rd_req, rd_ack = 0, rd_valid = 0, buf_we;
  logic [31:0] rd_addr;
  logic [63:0] rd_data = 0;
  logic [8:0]  buf_addr;
  logic [35:0] buf_data;

  int checks = 0, errors = 0;
  logic [31:0] b_rowbase, b_addr;
  int b_bursts = 0, b_left = 0;
  bit b_on = 0;

  scanline_fetch dut_i (.clk(clk), .rst_n(rst_n), .disp_en(disp_en), .frame_base(frame_base),
    .line_req(line_req), .line_row(line_row), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_valid(rd_valid), .rd_data(rd_data), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_data(buf_data));

  always #10 clk = ~clk;

  function automatic logic [31:0] pw(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ (a >> 7) ^ 32'h5A5A1234;
  endfunction
  function automatic logic [17:0] px(input logic [31:0] w);
    return {w[23:18], w[15:10], w[7:2]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit lreq, input logic [8:0] row, input bit en);
    bit ack_now = 0, real_v = 0;
    bit exp_req;
    @(negedge clk);
    disp_en = en; line_req = lreq; line_row = row; rd_ack = 0; rd_valid = 0;
    if ($urandom % 8 == 0) frame_base = $urandom;
    #1;
    exp_req = en && b_on && b_left == 0 && b_bursts < 20;
    chk(rd_req == exp_req, "R3 rd_req level", rd_req, exp_req);
    if (rd_req && exp_req) begin
      chk(rd_addr == b_rowbase + 32'(b_bursts) * 128, "R1 burst address", rd_addr,
          b_rowbase + 32'(b_bursts) * 128);
      if ($urandom % 2 == 0) begin rd_ack = 1; ack_now = 1; end
    end
    if (b_left > 0 && $urandom % 100 < 65) begin
      rd_valid = 1; real_v = 1; rd_data = {pw(b_addr), pw(b_addr + 4)};
    end else if (b_left == 0 && $urandom % 6 == 0) begin
      rd_valid = 1; rd_data = {$urandom, $urandom};
    end
    #1;
    chk(buf_we == (real_v && en), "R4 buf_we", buf_we, real_v && en);
    if (buf_we && real_v && en) begin
      chk(buf_addr == 9'((b_addr - b_rowbase) / 8), "R6 buf_addr", buf_addr, (b_addr - b_rowbase) / 8);
      chk(buf_data == {px(pw(b_addr)), px(pw(b_addr + 4))}, "R5 packing", buf_data,
          {px(pw(b_addr)), px(pw(b_addr + 4))});
    end
    if (!en) begin
      b_on = 0; b_left = 0;
    end else if (lreq && row < 480) begin
      b_rowbase = (frame_base & 32'hFFE0_0000) + 32'(row) * 4096;
      b_bursts = 0; b_left = 0; b_on = 1;
    end else begin
      if (ack_now) begin
        b_left = 16; b_addr = b_rowbase + 32'(b_bursts) * 128; b_bursts++;
      end else if (real_v) begin
        b_left--; b_addr += 8;
        if (b_left == 0 && b_bursts == 20) b_on = 0;
      end
    end
    @(posedge clk);
  endtask

  task automatic run_line(input logic [8:0] row, input int limit);
    cycle(1, row, 1);
    for (int i = 0; i < limit && b_on; i++) cycle(0, 0, 1);
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(rd_req == 0 && buf_we == 0, "R3 reset state", {rd_req, buf_we}, 0);
    @(negedge clk); rst_n = 1;
    frame_base = 32'hF01F_FFFF;
    // R1 R2 directed rows 0 and 479 to completion
    run_line(0, 5000);
    chk(!b_on, "R2 row 0 completed", b_on, 0);
    for (int i = 0; i < 10; i++) cycle(0, 0, 1);
    run_line(479, 5000);
    chk(!b_on, "R2 row 479 completed", b_on, 0);
    // R9 out-of-range rows while idle and mid-row
    cycle(1, 9'd480, 1);
    for (int i = 0; i < 8; i++) cycle(0, 0, 1);
    cycle(1, 9'd7, 1);
    for (int i = 0; i < 60; i++) cycle(0, 0, 1);
    cycle(1, 9'd511, 1);
    for (int i = 0; i < 40; i++) cycle(0, 0, 1);
    // R7 abandon mid-row
    cycle(1, 9'd100, 1);
    for (int i = 0; i < 300; i++) cycle(0, 0, 1);
    run_line(101, 5000);
    // R8 disable mid-row with an ignored request
    cycle(1, 9'd200, 1);
    for (int i = 0; i < 150; i++) cycle(0, 0, 1);
    for (int i = 0; i < 5; i++) cycle(i == 2, 9'd3, 0);
    for (int i = 0; i < 20; i++) cycle(0, 0, 1);
    chk(rd_req == 0, "R8 idle after re-enable", rd_req, 0);
    // random mix
    for (int n = 0; n < 25; n++) begin
      if ($urandom % 4 == 0) begin
        cycle(1, 9'($urandom % 480), 1);
        for (int i = 0; i < int'($urandom % 400); i++) cycle(0, 0, 1);
      end else begin
        run_line(9'($urandom % 480), 5000);
      end
      for (int i = 0; i < int'($urandom % 5); i++) cycle(0, 0, 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule